// File: doc/BRIEF.md
# Clock-Fail-Safe Watchdog Timer

This block combines a watchdog timer with a detector that notices when the external main clock has stopped. The whole block runs from the always-running internal oscillator clock. The external clock is sampled as data and its rising edges are counted over fixed windows. If a whole window passes with no edge, the block raises a sticky stop flag. It also moves the system clock select over to the internal oscillator. That move is permanent until the next reset.

Before the switch, the watchdog prescaler advances once per external rising edge. After the switch it advances on every internal oscillator cycle, so a dead main clock can never freeze the timeout. Software refreshes the timer by writing a two-byte key. When the timer underflows it produces either a multi-cycle reset request or a single-cycle interrupt, chosen by a mode input. The switched system clock is modelled as a select line plus a clock enable. The enable is divided by eight once the internal oscillator is in use.

Top module: `clk_failsafe_wdt`

## Requirements
- R1: After synchronous reset, clk_sel=0, osc_stop=0, wdt_rst_req=0, wdt_irq=0 and sys_clk_en=1.
- R2: With mon_en=1, a window of WIN (default 16) internal cycles with no synchronised rising edge of ext_clk sets osc_stop and clk_sel within two windows plus synchroniser delay. While ext_clk rises at least once per window, neither is set. With mon_en=0 nothing is ever detected.
- R3: Once clk_sel is 1 it stays 1 until reset, even when ext_clk toggles again.
- R4: osc_stop stays 1 until a stop_clr pulse. stop_clr has no effect on clk_sel. A detection and a clear in the same cycle leave osc_stop at 1.
- R5: sys_clk_en is 1 every cycle while clk_sel=0. After the switch it is 1 in exactly one of every 8 cycles.
- R6: The watchdog tick is a synchronised rising edge of ext_clk while clk_sel=0, and every internal cycle while clk_sel=1.
- R7: The timeout is 2^CNT_W * 2^PRE_W ticks after a reload. With internal ticks, the underflow output appears 513 cycles after the cycle that accepted the refresh write when CNT_W=5 and PRE_W=4.
- R8: A write of 8'h55 arms the key. A write of 8'hAA while armed reloads the counter and prescaler. Any other write disarms the key. A write of 8'hAA while not armed is ignored.
- R9: On underflow with rst_mode=1, wdt_rst_req is 1 for exactly 4 cycles and wdt_irq stays 0. With rst_mode=0, wdt_irq pulses for one cycle and wdt_rst_req stays 0.
- R10: While wdt_en=0 the counter is held at its reload value and no underflow output occurs.
- R11: After an underflow the counter reloads by itself and underflows again one full timeout later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | External main clock, sampled as data |
| mon_en | input | 1 | Enables the stop detector |
| wdt_en | input | 1 | Enables watchdog counting |
| rst_mode | input | 1 | 1: underflow requests reset; 0: underflow raises interrupt |
| wr_en | input | 1 | Key write strobe |
| wr_data | input | 8 | Key write byte |
| stop_clr | input | 1 | Clears the stop flag |
| clk_sel | output | 1 | System clock select, 1 = internal oscillator |
| sys_clk_en | output | 1 | System clock enable (divided after switch) |
| osc_stop | output | 1 | Sticky main-clock stop flag |
| wdt_rst_req | output | 1 | Watchdog reset request |
| wdt_irq | output | 1 | Watchdog interrupt pulse |

## Verification
Two events can land in the same cycle. A stop detection can coincide with a software clear of the stop flag. A refresh write can also land between underflows while the tick source changes. The first case is provoked by holding stop_clr high while ext_clk stays frozen, so that each window's detection meets an active clear. It is judged by seeing osc_stop read as 1 at least once during the hold. Refresh timing is judged by driving random write streams mixed with genuine key pairs. A bench model tracks the arm state and the last accepted refresh, and the cycle of the next underflow must match that model.

// File: rtl/cfw_pkg.sv
package cfw_pkg;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  typedef enum logic {SRC_EXT = 1'b0, SRC_INT = 1'b1} clk_src_e;

  function automatic logic pick_tick(input clk_src_e src, input logic ext_edge);
    return (src == SRC_INT) ? 1'b1 : ext_edge;
  endfunction
endpackage

// File: rtl/cfw_stop_det.sv
module cfw_stop_det #(
  parameter int WIN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_clk,
  input  logic mon_en,
  output logic ext_rise,
  output logic stop_hit
);
  localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [WW-1:0] WLAST = WW'(WIN - 1);

  logic [2:0]    smp_q;
  logic [WW-1:0] win_q;
  logic          seen_q;
  logic          hit_q;

  assign ext_rise = smp_q[1] & ~smp_q[2];
  assign stop_hit = hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q  <= '0;
      win_q  <= '0;
      seen_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      smp_q <= {smp_q[1:0], ext_clk};
      if (!mon_en) begin
        win_q  <= '0;
        seen_q <= 1'b0;
        hit_q  <= 1'b0;
      end else begin
        win_q  <= (win_q == WLAST) ? '0 : win_q + 1'b1;
        seen_q <= (win_q == WLAST) ? 1'b0 : (seen_q | ext_rise);
        hit_q  <= (win_q == WLAST) && !(seen_q | ext_rise);
      end
    end
  end

  assert_hit_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> ($past(mon_en) && !$past(ext_rise)));
endmodule

// File: rtl/cfw_clk_switch.sv
module cfw_clk_switch #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic stop_hit,
  input  logic stop_clr,
  output logic clk_sel,
  output logic clk_en,
  output logic osc_stop
);
  import cfw_pkg::*;
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DLAST = DW'(DIV - 1);

  clk_src_e      src_q;
  logic [DW-1:0] div_q;
  logic          en_q;
  logic          flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= SRC_EXT;
      div_q  <= '0;
      en_q   <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      if (stop_hit) src_q <= SRC_INT;
      if (src_q == SRC_INT) begin
        div_q <= (div_q == DLAST) ? '0 : div_q + 1'b1;
        en_q  <= (div_q == DLAST);
      end else begin
        div_q <= '0;
        en_q  <= 1'b1;
      end
      if (stop_hit)      flag_q <= 1'b1;
      else if (stop_clr) flag_q <= 1'b0;
    end
  end

  assign clk_sel  = (src_q == SRC_INT);
  assign clk_en   = en_q;
  assign osc_stop = flag_q;

  assert_sel_oneway_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clk_sel)) |-> clk_sel);
  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(osc_stop) && !$past(stop_clr)) |-> osc_stop);
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stop_hit)) |-> (osc_stop && clk_sel));
  assert_en_full_R5: assert property (@(posedge clk) disable iff (rst)
    !clk_sel |-> clk_en);
endmodule

// File: rtl/cfw_key_unlock.sv
module cfw_key_unlock (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       reload
);
  import cfw_pkg::*;
  logic armed_q;
  logic fire_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= wr_en && (wr_data == KEY_FIRE) && armed_q;
      if (wr_en) armed_q <= (wr_data == KEY_ARM);
    end
  end

  assign reload = fire_q;

  assert_fire_armed_R8: assert property (@(posedge clk) disable iff (rst)
    reload |-> ($past(armed_q) && $past(wr_en)));
endmodule

// File: rtl/cfw_wdt_core.sv
module cfw_wdt_core #(
  parameter int CNT_W   = 15,
  parameter int PRE_W   = 4,
  parameter int RST_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic reload,
  input  logic rst_mode,
  output logic rst_req,
  output logic irq
);
  localparam int RW = $clog2(RST_LEN + 1);
  localparam logic [RW-1:0] RLAST = RW'(RST_LEN - 1);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RW-1:0]    rcnt_q;
  logic             rst_q;
  logic             irq_q;
  logic             uf;

  assign uf = en && !reload && tick && (pre_q == '1) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      cnt_q  <= '1;
      rcnt_q <= '0;
      rst_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (!en || reload) begin
        pre_q <= '0;
        cnt_q <= '1;
      end else if (tick) begin
        pre_q <= pre_q + 1'b1;
        if (pre_q == '1) cnt_q <= cnt_q - 1'b1;
      end
      irq_q  <= uf && !rst_mode;
      rst_q  <= (uf && rst_mode) || (rcnt_q != '0);
      if (uf && rst_mode)     rcnt_q <= RLAST;
      else if (rcnt_q != '0)  rcnt_q <= rcnt_q - 1'b1;
    end
  end

  assign rst_req = rst_q;
  assign irq     = irq_q;

  assert_quiet_off_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> (!irq_q && !$rose(rst_q)));
  assert_rst_stretch_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_q) |=> rst_q);
  assert_out_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(rst_q && irq_q));
endmodule

// File: rtl/clk_failsafe_wdt.sv
module clk_failsafe_wdt #(
  parameter int WIN     = 16,
  parameter int DIV     = 8,
  parameter int CNT_W   = 15,
  parameter int PRE_W   = 4,
  parameter int RST_LEN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_clk,
  input  logic       mon_en,
  input  logic       wdt_en,
  input  logic       rst_mode,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       stop_clr,
  output logic       clk_sel,
  output logic       sys_clk_en,
  output logic       osc_stop,
  output logic       wdt_rst_req,
  output logic       wdt_irq
);
  import cfw_pkg::*;

  logic ext_rise;
  logic stop_hit;
  logic reload;
  logic tick;

  cfw_stop_det #(.WIN(WIN)) u_det (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .mon_en(mon_en),
    .ext_rise(ext_rise), .stop_hit(stop_hit));

  cfw_clk_switch #(.DIV(DIV)) u_sw (
    .clk(clk), .rst(rst), .stop_hit(stop_hit), .stop_clr(stop_clr),
    .clk_sel(clk_sel), .clk_en(sys_clk_en), .osc_stop(osc_stop));

  cfw_key_unlock u_key (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .reload(reload));

  assign tick = pick_tick(clk_sel ? SRC_INT : SRC_EXT, ext_rise);

  cfw_wdt_core #(.CNT_W(CNT_W), .PRE_W(PRE_W), .RST_LEN(RST_LEN)) u_core (
    .clk(clk), .rst(rst), .en(wdt_en), .tick(tick), .reload(reload),
    .rst_mode(rst_mode), .rst_req(wdt_rst_req), .irq(wdt_irq));

  assert_tick_int_R6: assert property (@(posedge clk) disable iff (rst)
    clk_sel |-> tick);
endmodule

// File: tb/sim_clk_failsafe_wdt.sv
module sim_clk_failsafe_wdt;
  logic clk = 1'b0, rst = 1'b1, ext_clk = 1'b0;
  logic mon_en = 1'b1, wdt_en = 1'b0, rst_mode = 1'b0, wr_en = 1'b0, stop_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic clk_sel, sys_clk_en, osc_stop, wdt_rst_req, wdt_irq;
  bit ext_run = 1'b1;
  int cyc = 0, total = 0, bad = 0;

  clk_failsafe_wdt #(.CNT_W(5), .PRE_W(4)) u0 (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .mon_en(mon_en), .wdt_en(wdt_en),
    .rst_mode(rst_mode), .wr_en(wr_en), .wr_data(wr_data), .stop_clr(stop_clr),
    .clk_sel(clk_sel), .sys_clk_en(sys_clk_en), .osc_stop(osc_stop),
    .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq));

  always #4 clk = ~clk;
  always #24 if (ext_run) ext_clk = ~ext_clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit near(input int a, input int e, input int tol);
    return (a >= e - tol) && (a <= e + tol);
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_out(input bit want_rst, input int lim, output int n);
    n = 0;
    while (!(want_rst ? wdt_rst_req : wdt_irq) && n < lim) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    #(8 * 190000);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, t1, cnt, last, flips;
    bit armed, seen;
    logic [7:0] d;
    void'($urandom(32'd1234));
    do_reset();
    @(negedge clk);
    chk(!clk_sel, "R1 clk_sel", clk_sel, 0);
    chk(!osc_stop, "R1 osc_stop", osc_stop, 0);
    chk(!wdt_rst_req && !wdt_irq, "R1 outputs", wdt_rst_req | wdt_irq, 0);
    chk(sys_clk_en, "R1 sys_clk_en", sys_clk_en, 1);

    // R2/R5: running external clock, no detection, full enable
    flips = 0;
    repeat (200) begin @(negedge clk); if (clk_sel || osc_stop || !sys_clk_en) flips++; end
    chk(flips == 0, "R2 R5 no false stop", flips, 0);

    // R6/R7 external ticks, interrupt mode
    wdt_en = 1'b1; rst_mode = 1'b0;
    wr(8'h55); wr(8'hAA);
    seen = 0; n = 0;
    while (!wdt_irq && n < 4000) begin @(negedge clk); n++; if (wdt_rst_req) seen = 1; end
    chk(near(n, 3072, 16), "R6 R7 external timeout", n, 3072);
    chk(!seen, "R9 no reset in irq mode", seen, 0);
    @(negedge clk);
    chk(!wdt_irq, "R9 irq one cycle", wdt_irq, 0);

    // R2 stop detection, R5 divide
    ext_run = 0;
    repeat (40) @(negedge clk);
    chk(osc_stop && clk_sel, "R2 stop detected", {osc_stop, clk_sel}, 3);
    cnt = 0;
    repeat (64) begin @(negedge clk); if (sys_clk_en) cnt++; end
    chk(cnt == 8, "R5 divided enable", cnt, 8);

    // R7/R9/R11 internal ticks, reset mode
    rst_mode = 1'b1;
    wr(8'h55); wr(8'hAA);
    wait_out(1, 1000, n);
    chk(near(n, 513, 1), "R7 internal timeout", n, 513);
    t1 = cyc; cnt = 0; seen = 0;
    while (wdt_rst_req && cnt < 20) begin cnt++; if (wdt_irq) seen = 1; @(negedge clk); end
    chk(cnt == 4, "R9 reset length", cnt, 4);
    chk(!seen, "R9 no irq in reset mode", seen, 0);
    wait_out(1, 1000, n);
    chk(near(cyc - t1, 512, 1), "R11 repeat underflow", cyc - t1, 512);

    // R8 directed ignored writes
    repeat (6) @(negedge clk);
    wr(8'h55); wr(8'hAA); last = cyc;
    wr(8'hAA); wr(8'h55); wr(8'h12); wr(8'hAA);
    wait_out(1, 1000, n);
    chk(near(cyc - last, 513, 1), "R8 stray writes ignored", cyc - last, 513);

    // R8 random write streams against model
    for (int round = 0; round < 3; round++) begin
      repeat (6) @(negedge clk);
      wr(8'h55); wr(8'hAA); last = cyc; armed = 0; seen = 0;
      for (int i = 0; i < 35; i++) begin
        repeat ($urandom_range(0, 3)) @(negedge clk);
        case ($urandom % 4)
          0: d = 8'h55;
          1: d = (round == 2) ? 8'h3C : 8'hAA;
          default: d = 8'($urandom);
        endcase
        wr(d);
        if (wdt_rst_req) seen = 1;
        if (d == 8'hAA && armed) last = cyc;
        armed = (d == 8'h55);
      end
      wait_out(1, 1000, n);
      chk(!seen && near(cyc - last, 513, 1), "R8 random refresh", cyc - last, 513);
    end

    // R3 one-way, R4 clear
    ext_run = 1;
    repeat (40) @(negedge clk);
    chk(clk_sel, "R3 stays internal", clk_sel, 1);
    @(negedge clk); stop_clr = 1'b1; @(negedge clk); stop_clr = 1'b0;
    chk(!osc_stop && clk_sel, "R4 clear flag only", {osc_stop, clk_sel}, 1);
    repeat (40) @(negedge clk);
    chk(!osc_stop, "R4 stays cleared", osc_stop, 0);
    ext_run = 0; stop_clr = 1'b1; seen = 0;
    repeat (60) begin @(negedge clk); if (osc_stop) seen = 1; end
    stop_clr = 1'b0;
    chk(seen, "R4 set wins over clear", seen, 1);

    // R2 monitor disabled
    mon_en = 1'b0; wdt_en = 1'b0;
    do_reset();
    flips = 0;
    repeat (100) begin @(negedge clk); if (clk_sel || osc_stop || !sys_clk_en) flips++; end
    chk(flips == 0, "R2 monitor off", flips, 0);

    // R10 watchdog disabled
    mon_en = 1'b1;
    repeat (40) @(negedge clk);
    cnt = 0;
    repeat (1200) begin @(negedge clk); if (wdt_rst_req || wdt_irq) cnt++; end
    chk(cnt == 0, "R10 disabled quiet", cnt, 0);
    @(negedge clk); wdt_en = 1'b1;
    wait_out(1, 1000, n);
    chk(near(n, 512, 2), "R10 held at reload", n, 512);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule